// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds eight hardware ownership flags that two independent ports, left and right, use to reserve a shared resource. A port claims a flag by writing 0 to it and gives it back by writing 1. Reading a flag tells the port whether it holds it. Each port sees its own view of the same latch: the holder reads 0 and the other side reads 1.

A claim made while the other side holds the flag is not lost. It is kept as a pending request and turns into ownership in the same clock cycle in which the holder releases. Writing 1 while the request is still waiting withdraws it. If both sides claim a free flag in the same cycle, a parameter chooses the winner and records the loser's claim as pending. The default winner is the left side.

Each port has a semaphore select that works as a chip select of its own. A read result is captured in a register and is driven on every bit of the data-out bus. The block shares its address pins with a memory array, so only the low address bits pick a flag. A cycle in which the memory enable is also asserted is dropped.

Top module: `sema_bank`

## Requirements
- R1: After reset no flag has an owner and none has a pending request. Both data-out buses read all ones, and a read of any flag on either port returns all ones.
- R2: Only address bits [2:0] select the flag. The higher address bits have no effect on which flag is read or written.
- R3: A write with data-in 0 to a free flag makes the writing side the owner. That side then reads 0 (all zeros) and the other side reads 1 (all ones). The two sides never own the same flag together.
- R4: Only the owner can change a flag's ownership. A write of 0 by the owner has no effect. A write of 1 by a side that neither owns the flag nor has a request pending has no effect.
- R5: When the owner writes 1 and the other side has a request pending, the other side becomes owner on that same clock edge. When no request is pending, the same write leaves the flag free, and it then reads 1 on both sides.
- R6: A write of 1 by a side whose request is pending withdraws the request. A later release by the owner then leaves the flag free.
- R7: When both sides write 0 to the same free flag in one cycle, the left side becomes owner and the right side's request becomes pending. This is the default tie-break.
- R8: A read captures the flag's value at the clock edge where the read strobe is sampled. The value is driven on all 16 data-out bits: all zeros for 0, all ones for 1. It holds until the next read on the same port, whatever the other port writes in the meantime.
- R9: A cycle in which a port asserts both semaphore select and memory enable is ignored. It changes no flag and does not update that port's data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_ce | input | 1 | Left memory enable, active high; makes the cycle invalid |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_din | input | 1 | Left write data: 0 claims, 1 releases |
| l_addr | input | 13 | Left address; bits [2:0] pick the flag |
| l_dout | output | 16 | Left registered read value, replicated |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_ce | input | 1 | Right memory enable, active high; makes the cycle invalid |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_din | input | 1 | Right write data: 0 claims, 1 releases |
| r_addr | input | 13 | Right address; bits [2:0] pick the flag |
| r_dout | output | 16 | Right registered read value, replicated |

## Verification
A write changes the flag on the clock edge that samples it. A read registers the value on its own sampling edge, so the result of a write is first visible one cycle after the write, when a read is issued. The bench drives each strobe on a falling edge, leaves it in place across exactly one rising edge, and samples data-out on the following falling edge, after the capturing register has settled. The hold checks sample data-out several cycles after the other port's writes, with no read in between, to confirm that the registered value has not moved.

// File: rtl/sema_pkg.sv
package sema_pkg;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;

   localparam int unsigned SEMA_COUNT_DEFAULT = 8;
   localparam int unsigned SEMA_ABUS_DEFAULT  = 13;
   localparam int unsigned SEMA_DOUT_DEFAULT  = 16;

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
   parameter int unsigned NUM_SEM = 8,
   parameter int unsigned ABUS_W  = 13,
   localparam int unsigned SEL_W  = $clog2(NUM_SEM)
) (
   input  logic              sem_sel,
   input  logic              mem_ce,
   input  logic              wr,
   input  logic              rd,
   input  logic              din,
   input  logic [ABUS_W-1:0] addr,
   output logic [NUM_SEM-1:0] claim_vec,
   output logic [NUM_SEM-1:0] drop_vec,
   output logic              rd_en,
   output logic [SEL_W-1:0]  idx
);

   logic cyc_ok;
   logic unused_hi_bits;

   // semaphore select with memory enable also active is an illegal cycle
   assign cyc_ok = sem_sel & ~mem_ce;
   assign idx    = addr[SEL_W-1:0];
   assign rd_en  = cyc_ok & rd;

   generate
      if (ABUS_W > SEL_W) begin : g_hi
         assign unused_hi_bits = ^addr[ABUS_W-1:SEL_W];
      end else begin : g_nohi
         assign unused_hi_bits = 1'b0;
      end
   endgenerate

   always_comb begin
      claim_vec = '0;
      drop_vec  = '0;
      if (cyc_ok && wr) begin
         claim_vec[idx] = ~din;
         drop_vec[idx]  = din;
      end
   end

endmodule

// File: rtl/sema_cell.sv
module sema_cell #(
   parameter sema_pkg::side_e TIE_WINNER = sema_pkg::SIDE_LEFT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_claim,
   input  logic l_drop,
   input  logic r_claim,
   input  logic r_drop,
   output logic own_l,
   output logic own_r,
   output logic pend_l,
   output logic pend_r
);

   logic tie_left;
   logic nx_own_l, nx_own_r, nx_pend_l, nx_pend_r;

   generate
      if (TIE_WINNER == sema_pkg::SIDE_LEFT) begin : g_tie_l
         assign tie_left = 1'b1;
      end else begin : g_tie_r
         assign tie_left = 1'b0;
      end
   endgenerate

   always_comb begin
      nx_own_l  = own_l;
      nx_own_r  = own_r;
      nx_pend_l = pend_l;
      nx_pend_r = pend_r;
      if (!own_l && !own_r) begin
         if (l_claim && r_claim) begin
            nx_own_l  = tie_left;
            nx_own_r  = ~tie_left;
            nx_pend_r = tie_left;
            nx_pend_l = ~tie_left;
         end else if (l_claim) begin
            nx_own_l = 1'b1;
         end else if (r_claim) begin
            nx_own_r = 1'b1;
         end
      end else if (own_l) begin
         nx_pend_r = (pend_r | r_claim) & ~r_drop;
         if (l_drop) begin
            nx_own_l  = 1'b0;
            nx_own_r  = nx_pend_r;
            nx_pend_r = 1'b0;
         end
      end else begin
         nx_pend_l = (pend_l | l_claim) & ~l_drop;
         if (r_drop) begin
            nx_own_r  = 1'b0;
            nx_own_l  = nx_pend_l;
            nx_pend_l = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_l  <= 1'b0;
         own_r  <= 1'b0;
         pend_l <= 1'b0;
         pend_r <= 1'b0;
      end else begin
         own_l  <= nx_own_l;
         own_r  <= nx_own_r;
         pend_l <= nx_pend_l;
         pend_r <= nx_pend_r;
      end
   end

endmodule

// File: rtl/sema_rdreg.sv
module sema_rdreg #(
   parameter int unsigned DOUT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              flag_val,
   output logic [DOUT_W-1:0] dout
);

   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held <= 1'b1;
      else if (rd_en) held <= flag_val;
   end

   assign dout = {DOUT_W{held}};

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
   parameter int unsigned     NUM_SEM    = sema_pkg::SEMA_COUNT_DEFAULT,
   parameter int unsigned     ABUS_W     = sema_pkg::SEMA_ABUS_DEFAULT,
   parameter int unsigned     DOUT_W     = sema_pkg::SEMA_DOUT_DEFAULT,
   parameter sema_pkg::side_e TIE_WINNER = sema_pkg::SIDE_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_mem_ce,
   input  logic              l_wr,
   input  logic              l_rd,
   input  logic              l_din,
   input  logic [ABUS_W-1:0] l_addr,
   output logic [DOUT_W-1:0] l_dout,
   input  logic              r_sem_sel,
   input  logic              r_mem_ce,
   input  logic              r_wr,
   input  logic              r_rd,
   input  logic              r_din,
   input  logic [ABUS_W-1:0] r_addr,
   output logic [DOUT_W-1:0] r_dout
);

   localparam int unsigned SEL_W = $clog2(NUM_SEM);

   generate
      if (NUM_SEM < 2 || NUM_SEM != (1 << SEL_W)) begin : g_bad_count
         $error("sema_bank: NUM_SEM must be a power of two, at least 2");
      end
      if (ABUS_W < SEL_W) begin : g_bad_abus
         $error("sema_bank: ABUS_W narrower than the flag index");
      end
      if (DOUT_W < 1) begin : g_bad_dout
         $error("sema_bank: DOUT_W must be at least 1");
      end
   endgenerate

   logic [NUM_SEM-1:0] l_claim_vec, l_drop_vec, r_claim_vec, r_drop_vec;
   logic [NUM_SEM-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;
   logic               l_rd_en, r_rd_en;
   logic [SEL_W-1:0]   l_idx, r_idx;

   sema_port_decode #(.NUM_SEM(NUM_SEM), .ABUS_W(ABUS_W)) u_dec_l (
      .sem_sel(l_sem_sel), .mem_ce(l_mem_ce), .wr(l_wr), .rd(l_rd),
      .din(l_din), .addr(l_addr), .claim_vec(l_claim_vec),
      .drop_vec(l_drop_vec), .rd_en(l_rd_en), .idx(l_idx)
   );

   sema_port_decode #(.NUM_SEM(NUM_SEM), .ABUS_W(ABUS_W)) u_dec_r (
      .sem_sel(r_sem_sel), .mem_ce(r_mem_ce), .wr(r_wr), .rd(r_rd),
      .din(r_din), .addr(r_addr), .claim_vec(r_claim_vec),
      .drop_vec(r_drop_vec), .rd_en(r_rd_en), .idx(r_idx)
   );

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
         sema_cell #(.TIE_WINNER(TIE_WINNER)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_claim(l_claim_vec[g]), .l_drop(l_drop_vec[g]),
            .r_claim(r_claim_vec[g]), .r_drop(r_drop_vec[g]),
            .own_l(own_l_vec[g]), .own_r(own_r_vec[g]),
            .pend_l(pend_l_vec[g]), .pend_r(pend_r_vec[g])
         );
      end
   endgenerate

   // each side reads 0 only for a flag it owns
   sema_rdreg #(.DOUT_W(DOUT_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en),
      .flag_val(~own_l_vec[l_idx]), .dout(l_dout)
   );

   sema_rdreg #(.DOUT_W(DOUT_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en),
      .flag_val(~own_r_vec[r_idx]), .dout(r_dout)
   );

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
   parameter int unsigned NUM_SEM  = 8,
   parameter int unsigned DOUT_W   = 16,
   parameter bit          TIE_LEFT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               l_sem_sel,
   input logic               l_mem_ce,
   input logic               r_sem_sel,
   input logic               r_mem_ce,
   input logic [DOUT_W-1:0]  l_dout,
   input logic [DOUT_W-1:0]  r_dout,
   input logic [NUM_SEM-1:0] own_l_vec,
   input logic [NUM_SEM-1:0] own_r_vec,
   input logic [NUM_SEM-1:0] pend_l_vec,
   input logic [NUM_SEM-1:0] pend_r_vec,
   input logic [NUM_SEM-1:0] l_claim_vec,
   input logic [NUM_SEM-1:0] l_drop_vec,
   input logic [NUM_SEM-1:0] r_claim_vec,
   input logic [NUM_SEM-1:0] r_drop_vec
);

   assert_dout_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (l_dout == '0 || l_dout == '1) && (r_dout == '0 || r_dout == '1));

   assert_illegal_l_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && l_mem_ce) |=> $stable(l_dout));

   assert_illegal_r_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sem_sel && r_mem_ce) |=> $stable(r_dout));

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
         assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(own_l_vec[g] && own_r_vec[g]));

         assert_no_self_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(own_l_vec[g] && pend_l_vec[g]) && !(own_r_vec[g] && pend_r_vec[g]));

         assert_l_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && !l_drop_vec[g]) |=> own_l_vec[g]);

         assert_r_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r_vec[g] && !r_drop_vec[g]) |=> own_r_vec[g]);

         assert_handover_to_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && l_drop_vec[g] && pend_r_vec[g] && !r_drop_vec[g])
            |=> own_r_vec[g]);

         assert_handover_to_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r_vec[g] && r_drop_vec[g] && pend_l_vec[g] && !l_drop_vec[g])
            |=> own_l_vec[g]);

         assert_withdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l_vec[g] && r_drop_vec[g]) |=> !pend_r_vec[g]);

         if (TIE_LEFT) begin : g_tie
            assert_tie_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
               (!own_l_vec[g] && !own_r_vec[g] && l_claim_vec[g] && r_claim_vec[g])
               |=> (own_l_vec[g] && pend_r_vec[g]));
         end
      end
   endgenerate

endmodule

bind sema_bank sema_bank_chk #(
   .NUM_SEM(NUM_SEM),
   .DOUT_W(DOUT_W),
   .TIE_LEFT(TIE_WINNER == sema_pkg::SIDE_LEFT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sem_sel(l_sem_sel), .l_mem_ce(l_mem_ce),
   .r_sem_sel(r_sem_sel), .r_mem_ce(r_mem_ce),
   .l_dout(l_dout), .r_dout(r_dout),
   .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
   .pend_l_vec(pend_l_vec), .pend_r_vec(pend_r_vec),
   .l_claim_vec(l_claim_vec), .l_drop_vec(l_drop_vec),
   .r_claim_vec(r_claim_vec), .r_drop_vec(r_drop_vec)
);

// File: tb/sema_bank_bench.sv
module sema_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ABUS_W     = 13;
   localparam int DOUT_W     = 16;
   localparam logic [DOUT_W-1:0] ONES  = '1;
   localparam logic [DOUT_W-1:0] ZEROS = '0;

   // vector: {l_wr, l_din, r_wr, r_din, flag[2:0], expect_left, expect_right}
   localparam int NV = 14;
   localparam logic [8:0] VEC [NV] = '{
      9'b1_0_0_0_000_0_1,  // R3 left claims free flag 0
      9'b0_0_1_0_000_0_1,  // R4 right claim is held as pending
      9'b1_0_0_0_000_0_1,  // R4 owner claims again, no effect
      9'b1_1_0_0_000_1_0,  // R5 left release hands flag 0 to right
      9'b0_0_1_1_000_1_1,  // R5 release with nothing pending frees
      9'b0_0_1_0_001_1_0,  // R3 right claims flag 1
      9'b1_1_0_0_001_1_0,  // R4 non-owner release, no effect
      9'b1_0_1_0_010_0_1,  // R7 tie on flag 2, left wins
      9'b1_1_0_0_010_1_0,  // R7 right's tied claim was pending
      9'b1_0_0_0_011_0_1,  // R3 left claims flag 3
      9'b0_0_1_0_011_0_1,  // R6 right pends
      9'b0_0_1_1_011_0_1,  // R6 right withdraws
      9'b1_1_0_0_011_1_1,  // R6 release frees after withdraw
      9'b0_0_1_1_001_1_1   // R5 right frees flag 1
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              l_sem_sel = 0, l_mem_ce = 0, l_wr = 0, l_rd = 0, l_din = 0;
   logic              r_sem_sel = 0, r_mem_ce = 0, r_wr = 0, r_rd = 0, r_din = 0;
   logic [ABUS_W-1:0] l_addr = '0, r_addr = '0;
   logic [DOUT_W-1:0] l_dout, r_dout;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sema_bank u_sema_bank (
      .clk(clk), .rst_n(rst_n),
      .l_sem_sel(l_sem_sel), .l_mem_ce(l_mem_ce), .l_wr(l_wr), .l_rd(l_rd),
      .l_din(l_din), .l_addr(l_addr), .l_dout(l_dout),
      .r_sem_sel(r_sem_sel), .r_mem_ce(r_mem_ce), .r_wr(r_wr), .r_rd(r_rd),
      .r_din(r_din), .r_addr(r_addr), .r_dout(r_dout)
   );

   task automatic check(input string req, input logic [DOUT_W-1:0] act,
                        input logic [DOUT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: set at falling edge, held across one rising edge
   task automatic cyc(input logic ls, lc, lw, lr, ld, input logic [ABUS_W-1:0] la,
                      input logic rs, rc, rw, rr, rd, input logic [ABUS_W-1:0] ra);
      @(negedge clk);
      l_sem_sel = ls; l_mem_ce = lc; l_wr = lw; l_rd = lr; l_din = ld; l_addr = la;
      r_sem_sel = rs; r_mem_ce = rc; r_wr = rw; r_rd = rr; r_din = rd; r_addr = ra;
      @(negedge clk);
      l_sem_sel = 0; l_mem_ce = 0; l_wr = 0; l_rd = 0; l_din = 0;
      r_sem_sel = 0; r_mem_ce = 0; r_wr = 0; r_rd = 0; r_din = 0;
   endtask

   task automatic read_both(input logic [ABUS_W-1:0] la, input logic [ABUS_W-1:0] ra);
      cyc(1, 0, 0, 1, 0, la, 1, 0, 0, 1, 0, ra);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset left dout", l_dout, ONES);
      check("R1 reset right dout", r_dout, ONES);
      for (int f = 0; f < 8; f++) begin
         read_both(ABUS_W'(f), ABUS_W'(f));
         check("R1 reset left read", l_dout, ONES);
         check("R1 reset right read", r_dout, ONES);
      end

      // table walk; upper address bits vary and must not matter (R2)
      for (int i = 0; i < NV; i++) begin
         logic [ABUS_W-1:0] wa, ra;
         wa = {ABUS_W'(i * 37) >> 3, VEC[i][4:2]};
         ra = {ABUS_W'(i * 91 + 5) >> 3, VEC[i][4:2]};
         cyc(VEC[i][8], 0, VEC[i][8], 0, VEC[i][7], wa,
             VEC[i][6], 0, VEC[i][6], 0, VEC[i][5], wa);
         read_both(ra, ra);
         check($sformatf("vector %0d left", i), l_dout, VEC[i][1] ? ONES : ZEROS);
         check($sformatf("vector %0d right", i), r_dout, VEC[i][0] ? ONES : ZEROS);
      end

      // R2 high address bits ignored on flag 4
      cyc(1, 0, 1, 0, 0, {10'h155, 3'd4}, 0, 0, 0, 0, 0, '0);
      read_both({10'h0AA, 3'd4}, {10'h3FF, 3'd4});
      check("R2 left owns flag 4", l_dout, ZEROS);
      check("R2 right sees flag 4 taken", r_dout, ONES);
      read_both({10'h0AA, 3'd5}, {10'h000, 3'd5});
      check("R2 flag 5 untouched", l_dout & r_dout, ONES);

      // R8 held values: left last read flag 5 (ones); reread flag 4 for zeros
      read_both(13'd4, 13'd4);
      check("R8 left reads owned flag", l_dout, ZEROS);
      cyc(0, 0, 0, 0, 0, '0, 1, 0, 1, 0, 0, 13'd4);   // right pends
      cyc(1, 0, 1, 0, 1, 13'd4, 0, 0, 0, 0, 0, '0);   // left releases, right owns
      repeat (2) @(negedge clk);
      check("R8 left dout held across release", l_dout, ZEROS);
      check("R8 right dout held across grant", r_dout, ONES);
      read_both(13'd4, 13'd4);
      check("R8 left new read", l_dout, ONES);
      check("R8 right new read", r_dout, ZEROS);

      // R8 read captured at its own edge while the other port writes
      cyc(1, 0, 0, 1, 0, 13'd6, 1, 0, 1, 0, 0, 13'd6);
      check("R8 read sees pre-write value", l_dout, ONES);
      read_both(13'd6, 13'd6);
      check("R8 right now owns flag 6", r_dout, ZEROS);
      cyc(0, 0, 0, 0, 0, '0, 1, 0, 1, 0, 1, 13'd6);

      // R9 illegal cycles: claim on flag 7 with memory enable set
      cyc(1, 1, 1, 0, 0, 13'd7, 0, 0, 0, 0, 0, '0);
      read_both(13'd7, 13'd7);
      check("R9 illegal claim ignored left", l_dout, ONES);
      check("R9 illegal claim ignored right", r_dout, ONES);
      read_both(13'd0, 13'd4);   // right dout becomes zeros (owns flag 4)
      cyc(0, 0, 0, 0, 0, '0, 1, 1, 0, 1, 0, 13'd7);
      check("R9 illegal read leaves dout", r_dout, ZEROS);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule